// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block keeps a processor core's privileged control state: a status word, a cause word, the exception return address, the exception vector base and the faulting address. It tells the pipeline when an enabled interrupt is pending. When the pipeline raises a trap, it performs the whole state change in one clock edge and issues a redirect to the vector address. It also drives the memory-management unit: a virtual-memory enable, the current privilege level and a one-cycle translation-cache flush strobe. It reports which data width (64 or 32 bits) is active for the current privilege level.

Timer and inter-processor interrupt sources post one-cycle set pulses. Pending bits stay set until software overwrites the cause word. An inter-processor interrupt also raises a run flag, so a halted core starts again. Compile-time feature parameters decide which enable bits of the status word can ever become set.

Status layout (bit: meaning): 0 trap enable, 1 floating-point enable, 2 vector enable, 3 compressed-instruction enable, 4 previous supervisor, 5 supervisor, 6 user 64-bit, 7 supervisor 64-bit, 15:8 interrupt mask, 16 virtual-memory enable, 31:17 always zero. Cause layout: 4:0 exception code, 23:16 pending interrupts (one bit per line), all other bits zero.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, status reads 0x000000A0 (supervisor and supervisor 64-bit set) when 64-bit support is built in, and 0x00000020 when it is not. Cause, exception PC, bad address and redirect PC read 0, and run, irq_take and tlb_flush read 0.
- R2: A status write stores the written value ANDed with a keep mask. The mask clears bits 31:17 in every build. It also clears bits 6 and 7 when 64-bit support is absent, bit 1 when the FPU is absent, bit 3 when compressed instructions are absent, and bit 2 when the vector unit is absent.
- R3: In the cycle after any status write or trap, tlb_flush is 1, vm_enable equals the new status bit 16 and supervisor equals the new status bit 5. tlb_flush is 0 in the cycle after a cycle with neither.
- R4: wide_mode is status bit 7 when status bit 5 is 1, and status bit 6 otherwise.
- R5: irq_take is 1 exactly when status bit 0 is 1 and (cause bits 23:16 AND status bits 15:8) is nonzero.
- R6: On a trap, status bit 0 is cleared, bit 5 is set, bit 4 takes the old bit 5, and every other bit keeps its value.
- R7: On a trap, cause bits 4:0 take the trap code while the pending bits are kept. The exception PC takes cur_pc, bad_addr takes fault_addr, and redirect_valid pulses for one cycle with redirect_pc equal to the exception vector.
- R8: A timer pulse sets cause bit 16+TIMER_IRQ (23 by default). An inter-processor pulse sets cause bit 16+IPI_IRQ (21 by default) and sets run to 1.
- R9: When a trap coincides with a status write or a cause write, the trap update wins. An interrupt set pulse in that same cycle is still recorded.
- R10: Pending bits hold across cycles without a cause write. A cause write replaces them, and a write of 0 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a synchronous trap this cycle |
| trap_code | input | CODE_W | Exception code of the trap |
| cur_pc | input | ADDR_W | PC of the trapping instruction |
| fault_addr | input | ADDR_W | Faulting data/instruction address |
| timer_set | input | 1 | Timer interrupt set pulse |
| ipi_set | input | 1 | Inter-processor interrupt set pulse |
| sr_we | input | 1 | Status write strobe |
| sr_wdata | input | 32 | Status write data |
| cause_we | input | 1 | Cause write strobe |
| cause_wdata | input | 32 | Cause write data |
| evec_we | input | 1 | Exception vector write strobe |
| evec_wdata | input | ADDR_W | Exception vector write data |
| status | output | 32 | Current status word |
| cause | output | 32 | Current cause word |
| epc | output | ADDR_W | Exception PC |
| bad_addr | output | ADDR_W | Captured faulting address |
| redirect_valid | output | 1 | One-cycle redirect pulse after a trap |
| redirect_pc | output | ADDR_W | Redirect target |
| supervisor | output | 1 | Current privilege is supervisor |
| wide_mode | output | 1 | 64-bit data width active |
| vm_enable | output | 1 | Virtual memory enable to the MMU |
| tlb_flush | output | 1 | Translation-cache flush strobe |
| irq_take | output | 1 | An enabled interrupt is pending |
| run | output | 1 | Core run flag |

## Verification
The interrupt decision is swept over all 256 pending patterns, eight mask patterns and both trap-enable values. This separates a correct AND-then-reduce from an OR, from a reduce of either operand alone, and from a missing trap-enable gate. Status writes use walking-one and all-ones patterns on two builds, one with every feature and one with none, so each filtered bit is seen both kept and cleared. Traps are taken from user and from supervisor level to tell a copied previous-supervisor bit from a constant one. They are also taken together with competing writes and set pulses, which exposes a wrong priority or lost pending bits.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int ADDR_W    = 64,
  parameter int CODE_W    = 5,
  parameter int TIMER_IRQ = 7,
  parameter int IPI_IRQ   = 5,
  parameter int HAS_WIDE  = 1,
  parameter int HAS_FPU   = 1,
  parameter int HAS_CMP   = 1,
  parameter int HAS_VEC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              timer_set,
  input  logic              ipi_set,
  input  logic              sr_we,
  input  logic [31:0]       sr_wdata,
  input  logic              cause_we,
  input  logic [31:0]       cause_wdata,
  input  logic              evec_we,
  input  logic [ADDR_W-1:0] evec_wdata,
  output logic [31:0]       status,
  output logic [31:0]       cause,
  output logic [ADDR_W-1:0] epc,
  output logic [ADDR_W-1:0] bad_addr,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              supervisor,
  output logic              wide_mode,
  output logic              vm_enable,
  output logic              tlb_flush,
  output logic              irq_take,
  output logic              run
);
  localparam int NIRQ   = 8;
  localparam int B_ET   = 0;
  localparam int B_PS   = 4;
  localparam int B_S    = 5;
  localparam int B_UX   = 6;
  localparam int B_SX   = 7;
  localparam int IM_LSB = 8;
  localparam int B_VM   = 16;
  localparam int IP_LSB = 16;
  localparam logic [31:0] KEEP = {15'd0, 1'b1, 8'hFF, (HAS_WIDE != 0), (HAS_WIDE != 0),
                                  1'b1, 1'b1, (HAS_CMP != 0), (HAS_VEC != 0), (HAS_FPU != 0), 1'b1};
  localparam logic [31:0] RESET_SR = 32'h0000_00A0 & KEEP;

  logic [31:0]       sr_q, sr_d, sr_trap;
  logic [NIRQ-1:0]   pend_q, pend_d, set_vec;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] evec_q;

  always_comb begin
    set_vec = '0;
    set_vec[TIMER_IRQ] = timer_set;
    set_vec[IPI_IRQ]   = set_vec[IPI_IRQ] | ipi_set;
    sr_trap = sr_q;
    sr_trap[B_ET] = 1'b0;
    sr_trap[B_PS] = sr_q[B_S];
    sr_trap[B_S]  = 1'b1;
    if (trap_req)   sr_d = sr_trap & KEEP;
    else if (sr_we) sr_d = sr_wdata & KEEP;
    else            sr_d = sr_q;
    pend_d = ((cause_we && !trap_req) ? cause_wdata[IP_LSB +: NIRQ] : pend_q) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q           <= RESET_SR;
      pend_q         <= '0;
      code_q         <= '0;
      evec_q         <= '0;
      epc            <= '0;
      bad_addr       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      tlb_flush      <= 1'b0;
      run            <= 1'b0;
    end else begin
      sr_q           <= sr_d;
      pend_q         <= pend_d;
      tlb_flush      <= trap_req | sr_we;
      redirect_valid <= trap_req;
      run            <= run | ipi_set;
      if (evec_we) evec_q <= evec_wdata;
      if (trap_req) begin
        code_q      <= trap_code;
        epc         <= cur_pc;
        bad_addr    <= fault_addr;
        redirect_pc <= evec_q;
      end else if (cause_we) begin
        code_q <= cause_wdata[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    cause = '0;
    cause[CODE_W-1:0]       = code_q;
    cause[IP_LSB +: NIRQ]   = pend_q;
  end

  assign status     = sr_q;
  assign supervisor = sr_q[B_S];
  assign vm_enable  = sr_q[B_VM];
  assign wide_mode  = sr_q[B_S] ? sr_q[B_SX] : sr_q[B_UX];
  assign irq_take   = sr_q[B_ET] && (|(pend_q & sr_q[IM_LSB +: NIRQ]));

  assert_raz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> (status[31:17] == 15'd0));

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we || trap_req) |=> (tlb_flush && vm_enable == status[B_VM]));

  assert_trap_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (supervisor && !status[B_ET] && status[B_PS] == $past(status[B_S])));

  assert_trap_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (redirect_valid && epc == $past(cur_pc) && bad_addr == $past(fault_addr)
                  && cause[CODE_W-1:0] == $past(trap_code)));

  assert_ipi_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_set |=> (run && cause[IP_LSB + IPI_IRQ]));

  assert_trap_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ((cause[IP_LSB +: NIRQ] & $past(cause[IP_LSB +: NIRQ])) == $past(cause[IP_LSB +: NIRQ])));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> ((cause[IP_LSB +: NIRQ] & $past(cause[IP_LSB +: NIRQ])) == $past(cause[IP_LSB +: NIRQ])));
endmodule

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        trap_req = 0;
  logic [4:0]  trap_code = 0;
  logic [63:0] cur_pc = 0, fault_addr = 0, evec_wdata = 0;
  logic        timer_set = 0, ipi_set = 0, sr_we = 0, cause_we = 0, evec_we = 0;
  logic [31:0] sr_wdata = 0, cause_wdata = 0;

  logic [31:0] status, cause, s1, c1;
  logic [63:0] epc, bad_addr, redirect_pc, e1, b1, r1;
  logic        redirect_valid, supervisor, wide_mode, vm_enable, tlb_flush, irq_take, run;
  logic        rv1, sup1, wm1, vm1, fl1, it1, run1;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  trap_ctrl u0 (.clk, .rst_n, .trap_req, .trap_code, .cur_pc, .fault_addr, .timer_set, .ipi_set,
    .sr_we, .sr_wdata, .cause_we, .cause_wdata, .evec_we, .evec_wdata,
    .status, .cause, .epc, .bad_addr, .redirect_valid, .redirect_pc, .supervisor, .wide_mode,
    .vm_enable, .tlb_flush, .irq_take, .run);

  trap_ctrl #(.HAS_WIDE(0), .HAS_FPU(0), .HAS_CMP(0), .HAS_VEC(0)) u1 (.clk, .rst_n, .trap_req,
    .trap_code, .cur_pc, .fault_addr, .timer_set, .ipi_set, .sr_we, .sr_wdata, .cause_we,
    .cause_wdata, .evec_we, .evec_wdata, .status(s1), .cause(c1), .epc(e1), .bad_addr(b1),
    .redirect_valid(rv1), .redirect_pc(r1), .supervisor(sup1), .wide_mode(wm1), .vm_enable(vm1),
    .tlb_flush(fl1), .irq_take(it1), .run(run1));

  function automatic logic [31:0] keep_mask(bit full);
    logic [31:0] m = 32'h0001_FFFF;
    if (!full) m &= ~32'h0000_00CE;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    trap_req = 0; sr_we = 0; cause_we = 0; evec_we = 0; timer_set = 0; ipi_set = 0;
  endtask

  task automatic wr_sr(logic [31:0] v);
    sr_we = 1; sr_wdata = v; tick();
  endtask

  task automatic wr_cause(logic [31:0] v);
    cause_we = 1; cause_wdata = v; tick();
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ims [8] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h55, 8'hAA, 8'h0F, 8'h24};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 64'hA0);
    chk("R1 status narrow", s1, 64'h20);
    chk("R1 cause", cause, 0);
    chk("R1 epc", epc, 0);
    chk("R1 badaddr", bad_addr, 0);
    chk("R1 redirect_pc", redirect_pc, 0);
    chk("R1 run/irq/flush", {run, irq_take, tlb_flush}, 0);

    // R2 filter, R3 MMU outputs
    wr_sr(32'hFFFF_FFFF);
    chk("R2 all ones full", status, 64'h1FFFF);
    chk("R2 all ones narrow", s1, {32'h0, keep_mask(0)});
    chk("R3 flush", {tlb_flush, vm_enable, supervisor}, 3'b111);
    tick();
    chk("R3 flush drops", tlb_flush, 0);
    for (int i = 0; i < 32; i++) begin
      wr_sr(32'h1 << i);
      chk("R2 walk full", status, {32'h0, (32'h1 << i) & keep_mask(1)});
      chk("R2 walk narrow", s1, {32'h0, (32'h1 << i) & keep_mask(0)});
      chk("R3 vm/sup", {tlb_flush, vm_enable, supervisor}, {1'b1, i == 16, i == 5});
    end

    // R4 width select
    for (int k = 0; k < 8; k++) begin
      logic s, ux, sx;
      s = k[0]; ux = k[1]; sx = k[2];
      wr_sr({24'h0, sx, ux, s, 5'h0});
      chk("R4 wide full", wide_mode, s ? sx : ux);
      chk("R4 wide narrow", wm1, 0);
    end

    // R5 interrupt decision sweep
    for (int p = 0; p < 256; p++)
      for (int m = 0; m < 8; m++)
        for (int e = 0; e < 2; e++) begin
          sr_we = 1; sr_wdata = {16'h0, ims[m], 7'h10, e[0]};
          cause_we = 1; cause_wdata = {8'h0, p[7:0], 16'h0};
          tick();
          chk("R5 irq_take", irq_take, (e == 1) && ((p[7:0] & ims[m]) != 0));
        end

    // R6/R7 trap from user level
    evec_we = 1; evec_wdata = 64'h8000_0100; tick();
    wr_sr(32'h0000_FF01);
    wr_cause(32'h0004_0003);
    trap_req = 1; trap_code = 5'd9; cur_pc = 64'h1234; fault_addr = 64'hDEAD; tick();
    chk("R6 status user trap", status, 64'hFF20);
    chk("R7 cause", cause, 64'h0004_0009);
    chk("R7 epc", epc, 64'h1234);
    chk("R7 badaddr", bad_addr, 64'hDEAD);
    chk("R7 redirect", {redirect_valid, redirect_pc}, {1'b1, 64'h8000_0100});
    chk("R3 trap flush", {tlb_flush, supervisor}, 2'b11);
    tick();
    chk("R7 redirect pulse", redirect_valid, 0);
    // trap from supervisor
    wr_sr(32'h0000_0021);
    trap_req = 1; trap_code = 5'd2; cur_pc = 64'h40; fault_addr = 64'h50; tick();
    chk("R6 status sup trap", status, 64'h30);

    // R8 set pulses
    wr_cause(0);
    timer_set = 1; tick();
    chk("R8 timer", cause, 64'h0080_0000);
    chk("R8 run still 0", run, 0);
    ipi_set = 1; tick();
    chk("R8 ipi", cause, 64'h00A0_0000);
    chk("R8 run", run, 1);

    // R10 sticky, R9 priority
    repeat (5) tick();
    chk("R10 sticky", cause, 64'h00A0_0000);
    wr_sr(32'h0000_0001);
    trap_req = 1; trap_code = 5'd17; sr_we = 1; sr_wdata = 32'h0000_FFFF;
    cause_we = 1; cause_wdata = 0; timer_set = 0; ipi_set = 0;
    tick();
    chk("R9 status trap wins", status, 64'h20);
    chk("R9 cause trap wins", cause, 64'h00A0_0011);
    wr_cause(0);
    trap_req = 1; trap_code = 5'd1; ipi_set = 1; tick();
    chk("R9 pulse kept", cause, 64'h0020_0001);
    wr_cause(0);
    chk("R10 clear", cause, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule